// File: doc/BRIEF.md
# Lockable SMM Save-Base Guard Register

This block is a single configuration byte that guards a fixed memory area holding the SMM save base. Firmware finds out whether protection is available by writing a query value, then arms the protection by setting a lock bit. After that the byte is frozen until reset. Two enables come out: one tells the normal-access path to turn the area into a blackhole, and the other opens the same area to SMM accesses. Address decode and routing of the area sit outside the block.

Every write first passes through a write mask, and the mask comes from a three-state machine. In ST_RESET the mask is 0xFF. In ST_QUERIED it covers only the lock bit (bit 1, value 0x02). In ST_LOCKED it is 0x00. When the feature-enable input is high, each write takes one transition out of the current state:
- T_DISCARD: a non-query write in ST_RESET, which clears the byte.
- T_QUERY: ST_RESET to ST_QUERIED, after which the byte reads 0x01, meaning "available in RAM".
- T_HOLD: a write in ST_QUERIED with the lock bit clear.
- T_LOCK: ST_QUERIED to ST_LOCKED.
- T_FROZEN: any write in ST_LOCKED.

When the feature-enable input is low, every write takes T_RAW: the masked value is stored and the state does not change.

Top module: `smbase_guard`

## Requirements
- R1: After reset the byte reads 0x00, the state is ST_RESET (mask 0xFF), and both enables are 0.
- R2: In ST_RESET with the feature enabled, a write of any value other than 0xFF is discarded. The byte then reads 0x00 and the enables stay 0, even when the lock bit (bit 1) is set.
- R3: In ST_RESET with the feature enabled, a write of 0xFF moves to ST_QUERIED. The byte then reads 0x01 and the enables stay 0.
- R4: In ST_QUERIED with the feature enabled, a write with bit 1 clear leaves the byte at 0x01. All other bits are masked off and the enables stay 0.
- R5: In ST_QUERIED with the feature enabled, a write with bit 1 set moves to ST_LOCKED. The byte then reads 0x02 and both enables are 1 from the clock edge that takes the write.
- R6: In ST_LOCKED every write is ignored. The byte stays 0x02 and both enables stay 1.
- R7: The blackhole enable and the SMM window enable are always equal, and they are 1 exactly in ST_LOCKED.
- R8: With the feature disabled, a write stores (old & ~mask) | (data & mask) and leaves the state and both enables unchanged.
- R9: In a cycle with no write, the byte and both enables hold.
- R10: Reset from ST_LOCKED restores the R1 state, including the 0xFF mask that discards the next non-query write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | DW | Byte write value |
| feat_en | input | 1 | Enables the query and lock handshake |
| rd_data | output | DW | Current byte value |
| blackhole_en | output | 1 | Turns normal accesses to the protected area into a blackhole |
| smm_window_en | output | 1 | Opens the protected area to SMM accesses |

## Verification
A write is sampled on one rising edge. The byte, the state and both enables all change on that same edge, because the only register on the path is the byte or the state register, and the read port and the enables are combinational from those registers. The bench drives each write on a falling edge and removes it on the next falling edge. It checks the read port and the enables at that second falling edge, which is half a cycle after the update and before any further write. The clocked properties use a one-cycle implication for the same reason.

// File: rtl/smbg_pkg.sv
package smbg_pkg;

    typedef enum logic [1:0] {
        ST_RESET   = 2'd0,
        ST_QUERIED = 2'd1,
        ST_LOCKED  = 2'd2
    } smbg_state_e;

    typedef enum logic [2:0] {
        T_NONE    = 3'd0,
        T_RAW     = 3'd1,
        T_DISCARD = 3'd2,
        T_QUERY   = 3'd3,
        T_HOLD    = 3'd4,
        T_LOCK    = 3'd5,
        T_FROZEN  = 3'd6
    } smbg_trans_e;

endpackage

// File: rtl/smbg_merge.sv
module smbg_merge
    import smbg_pkg::*;
#(
    parameter int DW       = 8,
    parameter int LOCK_BIT = 1
) (
    input  smbg_state_e     state,
    input  logic [DW-1:0]   cur_val,
    input  logic [DW-1:0]   wr_data,
    output logic [DW-1:0]   merged
);
    localparam logic [DW-1:0] LOCK_MASK = DW'(1) << LOCK_BIT;

    logic [DW-1:0] mask;

    always_comb begin
        unique case (state)
            ST_RESET:   mask = '1;
            ST_QUERIED: mask = LOCK_MASK;
            ST_LOCKED:  mask = '0;
            default:    mask = '0;
        endcase
    end

    assign merged = (cur_val & ~mask) | (wr_data & mask);

endmodule

// File: rtl/smbg_fsm.sv
module smbg_fsm
    import smbg_pkg::*;
#(
    parameter int              DW        = 8,
    parameter logic [DW-1:0]   QUERY_VAL = 8'hFF,
    parameter int              LOCK_BIT  = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            feat_en,
    input  logic [DW-1:0]   merged,
    output smbg_state_e     state_q,
    output smbg_trans_e     trans
);
    smbg_state_e state_d;

    always_comb begin
        state_d = state_q;
        trans   = T_NONE;
        if (wr_en) begin
            if (!feat_en) begin
                trans = T_RAW;
            end else begin
                unique case (state_q)
                    ST_RESET: begin
                        if (merged == QUERY_VAL) begin
                            trans   = T_QUERY;
                            state_d = ST_QUERIED;
                        end else begin
                            trans = T_DISCARD;
                        end
                    end
                    ST_QUERIED: begin
                        if (merged == QUERY_VAL) begin
                            trans = T_QUERY;
                        end else if (merged[LOCK_BIT]) begin
                            trans   = T_LOCK;
                            state_d = ST_LOCKED;
                        end else begin
                            trans = T_HOLD;
                        end
                    end
                    ST_LOCKED: trans = T_FROZEN;
                    default: begin
                        trans   = T_NONE;
                        state_d = ST_RESET;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/smbg_byte.sv
module smbg_byte
    import smbg_pkg::*;
#(
    parameter int              DW        = 8,
    parameter logic [DW-1:0]   INRAM_VAL = 8'h01,
    parameter int              LOCK_BIT  = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  smbg_trans_e     trans,
    input  logic [DW-1:0]   merged,
    output logic [DW-1:0]   val_q
);
    localparam logic [DW-1:0] LOCK_VAL = DW'(1) << LOCK_BIT;

    logic [DW-1:0] val_d;

    always_comb begin
        unique case (trans)
            T_NONE:            val_d = val_q;
            T_RAW, T_HOLD:     val_d = merged;
            T_DISCARD:         val_d = '0;
            T_QUERY:           val_d = INRAM_VAL;
            T_LOCK, T_FROZEN:  val_d = LOCK_VAL;
            default:           val_d = val_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

endmodule

// File: rtl/smbg_out.sv
module smbg_out
    import smbg_pkg::*;
(
    input  smbg_state_e state,
    output logic        blackhole_en,
    output logic        smm_window_en
);
    always_comb begin
        unique case (state)
            ST_LOCKED: begin
                blackhole_en  = 1'b1;
                smm_window_en = 1'b1;
            end
            default: begin
                blackhole_en  = 1'b0;
                smm_window_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/smbase_guard.sv
module smbase_guard
    import smbg_pkg::*;
#(
    parameter int              DW        = 8,
    parameter logic [DW-1:0]   QUERY_VAL = 8'hFF,
    parameter logic [DW-1:0]   INRAM_VAL = 8'h01,
    parameter int              LOCK_BIT  = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [DW-1:0]   wr_data,
    input  logic            feat_en,
    output logic [DW-1:0]   rd_data,
    output logic            blackhole_en,
    output logic            smm_window_en
);
    smbg_state_e   state_q;
    smbg_trans_e   trans;
    logic [DW-1:0] merged;
    logic [DW-1:0] val_q;

    smbg_merge #(.DW(DW), .LOCK_BIT(LOCK_BIT)) u_merge (
        .state   (state_q),
        .cur_val (val_q),
        .wr_data (wr_data),
        .merged  (merged)
    );

    smbg_fsm #(.DW(DW), .QUERY_VAL(QUERY_VAL), .LOCK_BIT(LOCK_BIT)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .feat_en (feat_en),
        .merged  (merged),
        .state_q (state_q),
        .trans   (trans)
    );

    smbg_byte #(.DW(DW), .INRAM_VAL(INRAM_VAL), .LOCK_BIT(LOCK_BIT)) u_byte (
        .clk    (clk),
        .rst_n  (rst_n),
        .trans  (trans),
        .merged (merged),
        .val_q  (val_q)
    );

    smbg_out u_out (
        .state         (state_q),
        .blackhole_en  (blackhole_en),
        .smm_window_en (smm_window_en)
    );

    assign rd_data = val_q;

endmodule

// File: rtl/smbase_guard_chk.sv
module smbase_guard_chk
    import smbg_pkg::*;
#(
    parameter int              DW        = 8,
    parameter logic [DW-1:0]   QUERY_VAL = 8'hFF,
    parameter logic [DW-1:0]   INRAM_VAL = 8'h01,
    parameter int              LOCK_BIT  = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [DW-1:0]   wr_data,
    input logic            feat_en,
    input logic [DW-1:0]   rd_data,
    input logic            blackhole_en,
    input logic            smm_window_en,
    input smbg_state_e     state
);
    localparam logic [DW-1:0] LOCK_VAL = DW'(1) << LOCK_BIT;

    // R7
    enables_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blackhole_en == smm_window_en) && (blackhole_en == (state == ST_LOCKED)));

    // R6
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blackhole_en |=> (blackhole_en && rd_data == LOCK_VAL));

    // R2
    discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESET && wr_en && feat_en && wr_data != QUERY_VAL)
        |=> (rd_data == '0 && state == ST_RESET));

    // R3
    query_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESET && wr_en && feat_en && wr_data == QUERY_VAL)
        |=> (rd_data == INRAM_VAL && state == ST_QUERIED));

    // R5
    lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_QUERIED && wr_en && feat_en && wr_data[LOCK_BIT])
        |=> (blackhole_en && rd_data == LOCK_VAL));

    // R8
    disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !feat_en) |=> ($stable(blackhole_en) && $stable(state)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(rd_data) && $stable(blackhole_en)));

endmodule

bind smbase_guard smbase_guard_chk #(
    .DW(DW), .QUERY_VAL(QUERY_VAL), .INRAM_VAL(INRAM_VAL), .LOCK_BIT(LOCK_BIT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .feat_en       (feat_en),
    .rd_data       (rd_data),
    .blackhole_en  (blackhole_en),
    .smm_window_en (smm_window_en),
    .state         (state_q)
);

// File: tb/smbase_guard_bench.sv
module smbase_guard_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       feat_en = 1'b1;
    logic [7:0] rd_data;
    logic       blackhole_en;
    logic       smm_window_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    smbase_guard u_smbase_guard (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .feat_en       (feat_en),
        .rd_data       (rd_data),
        .blackhole_en  (blackhole_en),
        .smm_window_en (smm_window_en)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_state(string req, logic [7:0] byte_exp, logic en_exp);
        check(req, rd_data, byte_exp);
        check(req, {7'd0, blackhole_en}, {7'd0, en_exp});
        check(req, {7'd0, smm_window_en}, {7'd0, en_exp});
    endtask

    task automatic do_write(logic [7:0] d, logic f);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        feat_en = f;
        @(negedge clk);
        wr_en   = 1'b0;
        feat_en = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        expect_state("R1", 8'h00, 1'b0);
    endtask

    task automatic t_discard();
        do_write(8'h5A, 1'b1);
        expect_state("R2", 8'h00, 1'b0);
        do_write(8'h02, 1'b1);
        expect_state("R2 lock bit before query", 8'h00, 1'b0);
    endtask

    task automatic t_disabled_raw();
        do_write(8'h3C, 1'b0);
        expect_state("R8 raw store in reset mask", 8'h3C, 1'b0);
        do_write(8'h00, 1'b1);
        expect_state("R2 discard after raw", 8'h00, 1'b0);
    endtask

    task automatic t_query();
        do_write(8'hFF, 1'b1);
        expect_state("R3", 8'h01, 1'b0);
    endtask

    task automatic t_partial();
        do_write(8'hFD, 1'b1);
        expect_state("R4 masked bits", 8'h01, 1'b0);
        do_write(8'h00, 1'b1);
        expect_state("R4 zero write", 8'h01, 1'b0);
        do_write(8'hFE, 1'b0);
        expect_state("R8 raw store in queried mask", 8'h03, 1'b0);
        do_write(8'h00, 1'b1);
        expect_state("R4 after raw", 8'h01, 1'b0);
    endtask

    task automatic t_lock();
        do_write(8'h06, 1'b1);
        expect_state("R5", 8'h02, 1'b1);
        check("R7 enables equal", {7'd0, blackhole_en}, {7'd0, smm_window_en});
    endtask

    task automatic t_frozen();
        do_write(8'h00, 1'b1);
        expect_state("R6 zero write", 8'h02, 1'b1);
        do_write(8'hFF, 1'b1);
        expect_state("R6 query write", 8'h02, 1'b1);
        do_write(8'h00, 1'b0);
        expect_state("R8 disabled while locked", 8'h02, 1'b1);
    endtask

    task automatic t_idle();
        wr_data = 8'hFF;
        for (int i = 0; i < 5; i++) @(negedge clk);
        expect_state("R9", 8'h02, 1'b1);
    endtask

    task automatic t_relock();
        do_reset();
        expect_state("R10 reset from lock", 8'h00, 1'b0);
        do_write(8'h07, 1'b1);
        expect_state("R10 mask back to full", 8'h00, 1'b0);
        do_write(8'hFF, 1'b1);
        expect_state("R3 second query", 8'h01, 1'b0);
        do_write(8'hFF, 1'b1);
        expect_state("R5 lock by all-ones", 8'h02, 1'b1);
    endtask

    initial begin
        t_reset_state();
        t_discard();
        t_disabled_raw();
        t_query();
        t_partial();
        t_lock();
        t_frozen();
        t_idle();
        t_relock();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 5000; c++) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule